// File: doc/BRIEF.md
# Registered Command Bus Stage with Power-Down Sequencing

This block is a one-register stage for a DDR3-style command and address bus. Chip selects, clock enables, on-die-termination controls, the three command strobes, the bank address and the row/column address are captured on each clock edge and driven out one cycle later. While the bus is in normal operation the stage is a plain pipeline register.

The block also tracks clock-enable power-down. When every clock-enable input is low, it releases the output groups, modelled by per-group output-enable signals, and drives the clock-enable outputs low. When any clock-enable input goes high again, it drives an exit sequence. The clock-enable outputs rise at once. Chip selects are held high for exactly one cycle. Termination controls pass straight through. The command and address outputs sit at fixed safe levels for a set number of cycles, and then the stage returns to plain forwarding.

A mode input selects two- or four-chip-select operation. The block raises a one-cycle flag when chip selects are used in a way that would select control-word access during a power-down transition.

Top module: `cmdbuf_pd_regstage`

## Requirements
- R1: While reset is high on a clock edge, the next outputs are: all three output enables low, clock-enable outputs 0, chip-select outputs all 1, ODT outputs 0, command strobes 1, bank and address 0, and error flag 0. The block then counts as powered down.
- R2: Outside reset, each clock-enable output equals its input from the previous cycle.
- R3: A cycle in which both clock-enable inputs are low makes the next cycle's chip-select, ODT and command output enables low. In that next cycle the clock-enable outputs are 0, the chip selects are 1, ODT is 0, the strobes are 1, and bank and address are 0.
- R4: In the first cycle with any clock-enable input high after a powered-down cycle (the exit cycle), all four chip-select outputs are 1 in the next cycle, whatever the inputs are. From the cycle after that they follow the inputs.
- R5: During the exit sequence, the ODT outputs equal the ODT inputs of the previous cycle.
- R6: The command strobes are driven 1, and bank and address are driven 0, for FIX_CYC output cycles, starting with the cycle after the exit cycle. After that they equal the previous cycle's inputs.
- R7: All three output enables are high in the cycle after the exit cycle, so the outputs are never undriven while a clock-enable output is high.
- R8: With any clock-enable input high and no exit sequence in progress, every output equals its input from the previous cycle, and all output enables are high.
- R9: With quad mode off (quad_en=0), chip-select outputs 3 and 2 are always 1, and chip-select inputs 3 and 2 have no effect on them.
- R10: With quad mode off, if chip-select inputs 1 and 0 are both low (active-low 0) in an exit cycle, or in an entry cycle (both clock enables low after a non-powered-down cycle), the error flag is 1 in the next cycle.
- R11: With quad mode on, the error flag is raised in the same way when more than two of the four chip-select inputs are low. Two or fewer low raise no error.
- R12: In every other cycle the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quad_en | input | 1 | 1 = four chip selects, 0 = two |
| cs_n_i | input | 4 | Chip selects, active low |
| cke_i | input | 2 | Clock enables |
| odt_i | input | 2 | Termination controls |
| ras_n_i | input | 1 | Row strobe |
| cas_n_i | input | 1 | Column strobe |
| we_n_i | input | 1 | Write strobe |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Row/column address |
| cs_n_o | output | 4 | Registered chip selects |
| cke_o | output | 2 | Registered clock enables |
| odt_o | output | 2 | Registered termination controls |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write strobe |
| ba_o | output | BA_W | Registered bank address |
| addr_o | output | ADDR_W | Registered address |
| oe_cs_o | output | 1 | Chip-select group driven |
| oe_odt_o | output | 1 | ODT group driven |
| oe_cmd_o | output | 1 | Command/address group driven |
| cw_err_o | output | 1 | Illegal chip-select use at a power-down transition |

## Verification
The bench builds the block with FIX_CYC=5, ADDR_W=14 and BA_W=3. The short fixed-output window lets power-down bursts of one to six cycles land during an exit sequence and cut it short. It also lets a whole exit sequence, forcing and release included, fit between random bursts many times in one run. The narrow address keeps the random values dense enough that any output left at a stale or fixed value shows up quickly.

// File: rtl/cmdbuf_pd_pkg.sv
package cmdbuf_pd_pkg;
    localparam int NUM_CS = 4;

    typedef enum logic [1:0] {
        PH_DOWN = 2'd0,
        PH_EXIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;
endpackage

// File: rtl/cmdbuf_pd_fsm.sv
module cmdbuf_pd_fsm
    import cmdbuf_pd_pkg::*;
#(
    parameter int FIX_CYC = 8,
    localparam int CNT_W  = $clog2(FIX_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_cke,
    output phase_e           phase_q,
    output logic [CNT_W-1:0] left_q,
    output logic             cs_force,
    output logic             fix_next,
    output logic             edge_cyc
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] left;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!any_cke) begin
            st_d.ph   = PH_DOWN;
            st_d.left = '0;
        end else begin
            unique case (st_q.ph)
                PH_DOWN: begin
                    st_d.ph   = PH_EXIT;
                    st_d.left = CNT_W'(FIX_CYC - 1);
                end
                PH_EXIT: begin
                    if (st_q.left == '0) st_d.ph = PH_RUN;
                    else                 st_d.left = st_q.left - 1'b1;
                end
                default: st_d.ph = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_DOWN;
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q  = st_q.ph;
    assign left_q   = st_q.left;
    assign cs_force = (st_q.ph == PH_DOWN) && any_cke;
    assign fix_next = cs_force || ((st_q.ph == PH_EXIT) && (st_q.left != '0));
    assign edge_cyc = cs_force || ((st_q.ph != PH_DOWN) && !any_cke);

    // R6: the window counter never exceeds its load value
    a_r6_left_bound: assert property (@(posedge clk) disable iff (rst)
        left_q <= CNT_W'(FIX_CYC - 1));

    // R6: an exit in progress counts down by one per cycle
    a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXIT && any_cke && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/cmdbuf_cs_guard.sv
module cmdbuf_cs_guard
    import cmdbuf_pd_pkg::*;
(
    input  logic              quad_en,
    input  logic [NUM_CS-1:0] cs_n,
    output logic              bad
);
    logic [NUM_CS-1:0] low_mask;
    logic [2:0]        low_cnt;

    always_comb begin
        low_mask = ~cs_n;
        low_cnt  = 3'($countones(low_mask));
        if (quad_en) bad = (low_cnt > 3'd2);
        else         bad = (cs_n[1:0] == 2'b00);
    end
endmodule

// File: rtl/cmdbuf_pd_regstage.sv
module cmdbuf_pd_regstage
    import cmdbuf_pd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BA_W    = 3,
    parameter int FIX_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quad_en,
    input  logic [NUM_CS-1:0] cs_n_i,
    input  logic [1:0]        cke_i,
    input  logic [1:0]        odt_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic [1:0]        cke_o,
    output logic [1:0]        odt_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              oe_cs_o,
    output logic              oe_odt_o,
    output logic              oe_cmd_o,
    output logic              cw_err_o
);
    localparam int CNT_W = $clog2(FIX_CYC + 1);

    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        logic [1:0]        cke;
        logic [1:0]        odt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              oe_cs;
        logic              oe_odt;
        logic              oe_cmd;
        logic              err;
    } bus_t;

    localparam bus_t BUS_IDLE = '{
        cs_n: '1, cke: '0, odt: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
        ba: '0, addr: '0, oe_cs: 1'b0, oe_odt: 1'b0, oe_cmd: 1'b0, err: 1'b0};

    logic              any_cke;
    phase_e            phase_q;
    logic [CNT_W-1:0]  left_q;
    logic              cs_force;
    logic              fix_next;
    logic              edge_cyc;
    logic              cs_bad;
    logic [NUM_CS-1:0] cs_eff;

    assign any_cke = |cke_i;

    cmdbuf_pd_fsm #(.FIX_CYC(FIX_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .any_cke  (any_cke),
        .phase_q  (phase_q),
        .left_q   (left_q),
        .cs_force (cs_force),
        .fix_next (fix_next),
        .edge_cyc (edge_cyc)
    );

    cmdbuf_cs_guard u_guard (
        .quad_en (quad_en),
        .cs_n    (cs_n_i),
        .bad     (cs_bad)
    );

    // upper chip selects exist only in quad mode
    for (genvar g = 0; g < NUM_CS; g++) begin : g_csmask
        if (g < 2) begin : g_low
            assign cs_eff[g] = cs_n_i[g];
        end else begin : g_high
            assign cs_eff[g] = cs_n_i[g] | ~quad_en;
        end
    end

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d     = BUS_IDLE;
        bus_d.cke = cke_i;
        bus_d.err = edge_cyc & cs_bad;
        if (any_cke) begin
            bus_d.oe_cs  = 1'b1;
            bus_d.oe_odt = 1'b1;
            bus_d.oe_cmd = 1'b1;
            bus_d.odt    = odt_i;
            bus_d.cs_n   = cs_force ? '1 : cs_eff;
            if (!fix_next) begin
                bus_d.ras_n = ras_n_i;
                bus_d.cas_n = cas_n_i;
                bus_d.we_n  = we_n_i;
                bus_d.ba    = ba_i;
                bus_d.addr  = addr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_q <= BUS_IDLE;
        else     bus_q <= bus_d;
    end

    assign cs_n_o   = bus_q.cs_n;
    assign cke_o    = bus_q.cke;
    assign odt_o    = bus_q.odt;
    assign ras_n_o  = bus_q.ras_n;
    assign cas_n_o  = bus_q.cas_n;
    assign we_n_o   = bus_q.we_n;
    assign ba_o     = bus_q.ba;
    assign addr_o   = bus_q.addr;
    assign oe_cs_o  = bus_q.oe_cs;
    assign oe_odt_o = bus_q.oe_odt;
    assign oe_cmd_o = bus_q.oe_cmd;
    assign cw_err_o = bus_q.err;

    a_r2_cke_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cke_o == $past(cke_i)));

    a_r3_released: assert property (@(posedge clk) disable iff (rst)
        !any_cke |=> (!oe_cs_o && !oe_odt_o && !oe_cmd_o && cke_o == 2'b00));

    a_r4_cs_high: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DOWN && any_cke) |=> (cs_n_o == '1));

    a_r5_odt_pass: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_RUN && any_cke) |=> (odt_o == $past(odt_i)));

    a_r6_fixed: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXIT && any_cke && left_q != '0) |=>
        (ras_n_o && cas_n_o && we_n_o && ba_o == '0 && addr_o == '0));

    a_r7_driven: assert property (@(posedge clk) disable iff (rst)
        (|cke_o) |-> (oe_cs_o && oe_odt_o && oe_cmd_o));

    a_r9_upper_cs: assert property (@(posedge clk) disable iff (rst)
        !quad_en |=> (cs_n_o[NUM_CS-1:2] == '1));

    a_r12_err_only_edge: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && any_cke) |=> !cw_err_o);
endmodule

// File: tb/sim_cmdbuf_pd_regstage.sv
module sim_cmdbuf_pd_regstage;
    localparam int AW  = 14;
    localparam int BW  = 3;
    localparam int FIX = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, quad_en, ras_n_i, cas_n_i, we_n_i;
    logic [3:0]    cs_n_i;
    logic [1:0]    cke_i, odt_i;
    logic [BW-1:0] ba_i;
    logic [AW-1:0] addr_i;
    logic [3:0]    cs_n_o;
    logic [1:0]    cke_o, odt_o;
    logic          ras_n_o, cas_n_o, we_n_o, oe_cs_o, oe_odt_o, oe_cmd_o, cw_err_o;
    logic [BW-1:0] ba_o;
    logic [AW-1:0] addr_o;

    cmdbuf_pd_regstage #(.ADDR_W(AW), .BA_W(BW), .FIX_CYC(FIX)) u0 (
        .clk(clk), .rst(rst), .quad_en(quad_en), .cs_n_i(cs_n_i), .cke_i(cke_i),
        .odt_i(odt_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .addr_i(addr_i), .cs_n_o(cs_n_o), .cke_o(cke_o), .odt_o(odt_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o),
        .addr_o(addr_o), .oe_cs_o(oe_cs_o), .oe_odt_o(oe_odt_o), .oe_cmd_o(oe_cmd_o),
        .cw_err_o(cw_err_o));

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state
    bit m_pd = 1'b1;
    int m_left = 0;
    int ph = 0;
    bit e_quad = 1'b0;
    logic [3:0]    e_cs;
    logic [1:0]    e_cke, e_odt;
    logic [2:0]    e_cmd, e_oe;
    logic [BW-1:0] e_ba;
    logic [AW-1:0] e_addr;
    logic          e_err;
    bit            e_edge;

    function automatic bit cs_illegal(bit q, logic [3:0] cs);
        int lows = 0;
        for (int k = 0; k < 4; k++) if (!cs[k]) lows++;
        return q ? (lows > 2) : (cs[1:0] == 2'b00);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compute outputs expected after the coming edge from current inputs
    task automatic predict();
        bit anyc = |cke_i;
        e_quad = quad_en;
        e_cs = 4'hF; e_cke = 2'b00; e_odt = 2'b00; e_cmd = 3'b111;
        e_ba = '0; e_addr = '0; e_oe = 3'b000; e_err = 1'b0; e_edge = 1'b0;
        if (rst) begin
            ph = 0; m_pd = 1'b1; m_left = 0;
        end else begin
            e_cke = cke_i;
            if (!anyc) begin
                ph = 1;
                e_edge = !m_pd;
                e_err = e_edge && cs_illegal(quad_en, cs_n_i);
                m_pd = 1'b1;
            end else begin
                e_oe = 3'b111; e_odt = odt_i;
                e_cs = quad_en ? cs_n_i : {2'b11, cs_n_i[1:0]};
                if (m_pd) begin
                    ph = 2; e_edge = 1'b1;
                    e_err = cs_illegal(quad_en, cs_n_i);
                    e_cs = 4'hF; m_pd = 1'b0; m_left = FIX - 1;
                end else if (m_left > 0) begin
                    ph = 3; m_left--;
                end else begin
                    ph = 4;
                    e_cmd = {ras_n_i, cas_n_i, we_n_i}; e_ba = ba_i; e_addr = addr_i;
                end
            end
        end
    endtask

    task automatic compare();
        string t_cke, t_oe, t_cs, t_hi, t_odt, t_cmd, t_err;
        t_cke = (ph == 0) ? "R1" : "R2";
        t_oe  = (ph == 0) ? "R1" : (ph == 1) ? "R3" : (ph == 2) ? "R7" : "R8";
        t_cs  = (ph == 0) ? "R1" : (ph == 1) ? "R3" : (ph == 2) ? "R4" : "R8";
        t_hi  = (ph == 2) ? "R4" : (!e_quad ? "R9" : t_cs);
        t_odt = (ph == 2 || ph == 3) ? "R5" : t_cs;
        t_cmd = (ph == 2 || ph == 3) ? "R6" : t_cs;
        t_err = (ph == 0) ? "R1" : !e_edge ? "R12" : (e_quad ? "R11" : "R10");
        chk(t_cke, 32'(cke_o), 32'(e_cke));
        chk(t_oe,  32'({oe_cs_o, oe_odt_o, oe_cmd_o}), 32'(e_oe));
        chk(t_cs,  32'(cs_n_o[1:0]), 32'(e_cs[1:0]));
        chk(t_hi,  32'(cs_n_o[3:2]), 32'(e_cs[3:2]));
        chk(t_odt, 32'(odt_o), 32'(e_odt));
        chk(t_cmd, 32'({ras_n_o, cas_n_o, we_n_o}), 32'(e_cmd));
        chk(t_cmd, 32'(ba_o), 32'(e_ba));
        chk(t_cmd, 32'(addr_o), 32'(e_addr));
        chk(t_err, 32'(cw_err_o), 32'(e_err));
    endtask

    task automatic cyc();
        predict();
        @(negedge clk);
        compare();
    endtask

    task automatic rand_bus();
        ras_n_i = 1'($urandom); cas_n_i = 1'($urandom); we_n_i = 1'($urandom);
        ba_i = BW'($urandom); addr_i = AW'($urandom); odt_i = 2'($urandom);
        for (int k = 0; k < 4; k++) cs_n_i[k] = (($urandom % 4) != 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; quad_en = 1'b0; cs_n_i = 4'h0; cke_i = 2'b11; odt_i = 2'b11;
        ras_n_i = 1'b0; cas_n_i = 1'b0; we_n_i = 1'b0; ba_i = '1; addr_i = '1;
        @(negedge clk);
        cyc(); cyc();                               // R1 reset state under busy inputs
        rst = 1'b0; cke_i = 2'b00; cs_n_i = 4'hF;
        cyc(); cyc();                               // R3 held down
        // R4 R6 R10: exit with cs1/cs0 low, quad off, upper cs low ignored (R9)
        cke_i = 2'b01; cs_n_i = 4'b0000; rand_bus(); cs_n_i = 4'b0000;
        cyc();
        for (int i = 0; i < FIX + 3; i++) begin rand_bus(); cyc(); end   // R6 R8
        // R10: entry with cs1/cs0 low
        cke_i = 2'b00; cs_n_i = 4'b1100; cyc();
        cs_n_i = 4'hF; cyc();
        // R11: quad exit with two low -> no error
        quad_en = 1'b1; cke_i = 2'b10; cs_n_i = 4'b1010; cyc();
        for (int i = 0; i < FIX + 2; i++) begin rand_bus(); cyc(); end
        // R11: quad entry with three low -> error
        cke_i = 2'b00; cs_n_i = 4'b1000; cyc();
        // R11: quad exit with three low -> error, then cut short by power-down
        cke_i = 2'b11; cs_n_i = 4'b0001; cyc();
        rand_bus(); cyc();
        cke_i = 2'b00; cyc();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            rand_bus();
            if (($urandom % 60) == 0) quad_en = ~quad_en;
            if (($urandom % 12) == 0) cke_i = 2'b00;
            else if (cke_i == 2'b00 && ($urandom % 3) == 0) cke_i = 2'b00;
            else cke_i = 2'(($urandom % 3) + 1);
            if (($urandom % 500) == 0) rst = 1'b1; else rst = 1'b0;
            cyc();
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule